// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block resolves a fetched branch instruction into the next program counter. Each cycle that a valid strobe is high, it takes the address of the instruction, up to three instruction bytes and the four status flags (zero, negative, carry, overflow). It decodes which condition the opcode names, evaluates that condition against the flags and picks either the branch target or the fall-through address. One clock edge later it presents the result together with an output valid.

Two encodings are resolved. A short form is two bytes long: an opcode byte followed by an 8-bit signed displacement. An extended form is three bytes long: a prefix byte, a selector byte and the displacement. The target of a taken branch is the branch's own address plus the sign-extended displacement. The length of the instruction is not added to it. Any byte pattern that is not one of these branches raises an unsupported flag and leaves the address unchanged. This covers the loop-class opcodes as well as every other opcode.

Top module: `brr_resolve_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `res_valid`, `res_taken` and `res_unsup` become 0 and `res_next_pc` becomes 0.
- R2: The outputs update at the first rising edge where `req_valid` is sampled high. `res_valid` equals the `req_valid` sampled at the previous edge. When `req_valid` was low, `res_taken`, `res_unsup` and `res_next_pc` keep their values.
- R3: Signed short branches use `req_byte0` with `req_byte1` as the displacement: C0 is taken when N^V, C2 when !(N^V), C3 when Z|(N^V), and C1 when !(Z|(N^V)).
- R4: Unsigned short branches: C4 is taken when C, C6 when !C, C7 when C|Z, and C5 when !(C|Z).
- R5: C8 is taken when Z=1, C9 is taken when Z=0, and CA is always taken.
- R6: When `req_byte0`=F8, `req_byte1` selects the condition and `req_byte2` is the displacement: E8 is taken on !V, E9 on V, EA on !N and EB on N.
- R7: A taken branch gives `res_next_pc` = `req_pc` + sign-extended displacement, modulo 2^32.
- R8: A branch that is not taken gives `res_next_pc` = `req_pc` + 2 for the short forms and + 3 for the F8 forms, modulo 2^32.
- R9: Opcodes D0 through DB set `res_unsup`=1 and `res_taken`=0, and `res_next_pc` = `req_pc`.
- R10: Every other pattern behaves the same way as R9. This includes any byte0 outside C0–CA and F8, and F8 followed by a byte outside E8–EB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_pc | input | 32 | Address of the instruction |
| req_byte0 | input | 8 | First instruction byte |
| req_byte1 | input | 8 | Second instruction byte |
| req_byte2 | input | 8 | Third instruction byte |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| res_valid | output | 1 | Result valid |
| res_taken | output | 1 | Branch taken |
| res_unsup | output | 1 | Unsupported instruction |
| res_next_pc | output | 32 | Next program counter |

## Verification
Every result is due exactly one rising edge after the request is sampled. The bench drives a request on a falling edge. At the next falling edge it compares all four outputs with a behavioural model, which it advances by one step for each clock. Idle cycles are mixed between requests, so the model also checks that the data registers hold while `res_valid` is low.

// File: rtl/brr_pkg.sv
// Package: shared types and opcode constants for the branch resolution unit.
// Assumes: byte-wide opcodes; condition codes are internal only.
package brr_pkg;

    typedef enum logic [3:0] {
        COND_LT, COND_GT, COND_GE, COND_LE,
        COND_CS, COND_HI, COND_CC, COND_LS,
        COND_EQ, COND_NE, COND_AL,
        COND_VC, COND_VS, COND_NC, COND_NS
    } brr_cond_e;

    localparam logic [7:0] OP_EXT_PREFIX = 8'hF8;
    localparam logic [7:0] OP_SHORT_LO   = 8'hC0;
    localparam logic [7:0] OP_SHORT_HI   = 8'hCA;
    localparam logic [7:0] OP_EXT_LO     = 8'hE8;
    localparam logic [7:0] OP_EXT_HI     = 8'hEB;

endpackage

// File: rtl/brr_decode.sv
// Module: brr_decode
// Maps the instruction bytes to a condition, a form (short or extended),
// a displacement byte and a supported flag.
// Assumes: loop-class and all other opcodes simply fall to "not supported".
module brr_decode
    import brr_pkg::*;
#(
    parameter int DISP_W = 8
) (
    input  logic [7:0]        op0,
    input  logic [7:0]        op1,
    input  logic [7:0]        op2,
    output brr_cond_e         cond,
    output logic              is_ext,
    output logic              supported,
    output logic [DISP_W-1:0] disp
);

    // Opcode selection: short forms by first byte, extended forms by second byte.
    always_comb begin
        cond      = COND_AL;
        is_ext    = 1'b0;
        supported = 1'b0;
        disp      = op1[DISP_W-1:0];
        if (op0 >= OP_SHORT_LO && op0 <= OP_SHORT_HI) begin
            supported = 1'b1;
            case (op0[3:0])
                4'h0:    cond = COND_LT;
                4'h1:    cond = COND_GT;
                4'h2:    cond = COND_GE;
                4'h3:    cond = COND_LE;
                4'h4:    cond = COND_CS;
                4'h5:    cond = COND_HI;
                4'h6:    cond = COND_CC;
                4'h7:    cond = COND_LS;
                4'h8:    cond = COND_EQ;
                4'h9:    cond = COND_NE;
                default: cond = COND_AL;
            endcase
        end else if (op0 == OP_EXT_PREFIX && op1 >= OP_EXT_LO && op1 <= OP_EXT_HI) begin
            supported = 1'b1;
            is_ext    = 1'b1;
            disp      = op2[DISP_W-1:0];
            case (op1[1:0])
                2'd0:    cond = COND_VC;
                2'd1:    cond = COND_VS;
                2'd2:    cond = COND_NC;
                default: cond = COND_NS;
            endcase
        end
    end

endmodule

// File: rtl/brr_cond_eval.sv
// Module: brr_cond_eval
// Evaluates a decoded condition against the four status flags.
// Assumes: flags are stable for the cycle in which they are sampled.
module brr_cond_eval
    import brr_pkg::*;
(
    input  brr_cond_e cond,
    input  logic      fz,
    input  logic      fn,
    input  logic      fc,
    input  logic      fv,
    output logic      taken
);

    logic lt_sig;
    logic le_sig;
    logic ls_sig;

    // Shared signed/unsigned terms.
    always_comb begin
        lt_sig = fn ^ fv;
        le_sig = fz | lt_sig;
        ls_sig = fc | fz;
    end

    // Condition multiplexer.
    always_comb begin
        case (cond)
            COND_LT: taken = lt_sig;
            COND_GE: taken = ~lt_sig;
            COND_LE: taken = le_sig;
            COND_GT: taken = ~le_sig;
            COND_CS: taken = fc;
            COND_CC: taken = ~fc;
            COND_LS: taken = ls_sig;
            COND_HI: taken = ~ls_sig;
            COND_EQ: taken = fz;
            COND_NE: taken = ~fz;
            COND_VC: taken = ~fv;
            COND_VS: taken = fv;
            COND_NC: taken = ~fn;
            COND_NS: taken = fn;
            default: taken = 1'b1;
        endcase
    end

endmodule

// File: rtl/brr_target.sv
// Module: brr_target
// Forms the fall-through and taken addresses and selects the next PC.
// Assumes: the displacement is relative to the branch's own address;
// arithmetic wraps at the PC width.
module brr_target #(
    parameter int PC_W      = 32,
    parameter int DISP_W    = 8,
    parameter int SHORT_LEN = 2,
    parameter int EXT_LEN   = 3
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              is_ext,
    input  logic              supported,
    input  logic              taken,
    output logic [PC_W-1:0]   next_pc
);

    localparam logic [PC_W-1:0] SHORT_STEP = PC_W'(SHORT_LEN);
    localparam logic [PC_W-1:0] EXT_STEP   = PC_W'(EXT_LEN);

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] fall_pc;
    logic [PC_W-1:0] jump_pc;

    // Two adders in parallel, then a three-way select.
    always_comb begin
        disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
        fall_pc  = pc + (is_ext ? EXT_STEP : SHORT_STEP);
        jump_pc  = pc + disp_ext;
        if (!supported)  next_pc = pc;
        else if (taken)  next_pc = jump_pc;
        else             next_pc = fall_pc;
    end

endmodule

// File: rtl/brr_resolve_top.sv
// Module: brr_resolve_top
// Resolves one branch request per cycle. The result is registered and
// valid one edge after the request.
// Assumes: the caller holds no state of its own; the outputs hold between
// requests.
module brr_resolve_top
    import brr_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DISP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [PC_W-1:0] req_pc,
    input  logic [7:0]      req_byte0,
    input  logic [7:0]      req_byte1,
    input  logic [7:0]      req_byte2,
    input  logic            flag_z,
    input  logic            flag_n,
    input  logic            flag_c,
    input  logic            flag_v,
    output logic            res_valid,
    output logic            res_taken,
    output logic            res_unsup,
    output logic [PC_W-1:0] res_next_pc
);

    brr_cond_e         dec_cond;
    logic              dec_ext;
    logic              dec_ok;
    logic [DISP_W-1:0] dec_disp;
    logic              cond_true;
    logic [PC_W-1:0]   sel_pc;

    brr_decode #(.DISP_W(DISP_W)) u_dec (
        .op0(req_byte0), .op1(req_byte1), .op2(req_byte2),
        .cond(dec_cond), .is_ext(dec_ext), .supported(dec_ok), .disp(dec_disp)
    );

    brr_cond_eval u_eval (
        .cond(dec_cond), .fz(flag_z), .fn(flag_n), .fc(flag_c), .fv(flag_v),
        .taken(cond_true)
    );

    brr_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
        .pc(req_pc), .disp(dec_disp), .is_ext(dec_ext), .supported(dec_ok),
        .taken(cond_true), .next_pc(sel_pc)
    );

    // Result register: capture on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_taken   <= 1'b0;
            res_unsup   <= 1'b0;
            res_next_pc <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_taken   <= dec_ok & cond_true;
                res_unsup   <= ~dec_ok;
                res_next_pc <= sel_pc;
            end
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    assert_idle_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(res_next_pc)));

    assert_always_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_byte0 == 8'hCA) |=> (res_taken && !res_unsup));

    assert_loop_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_byte0 >= 8'hD0 && req_byte0 <= 8'hDB)
        |=> (res_unsup && res_next_pc == $past(req_pc)));

    assert_unsup_never_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_unsup) |-> !res_taken);

endmodule

// File: tb/tb_brr_resolve_top.sv
module tb_brr_resolve_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_pc = '0;
    logic [7:0]  req_byte0 = '0, req_byte1 = '0, req_byte2 = '0;
    logic        flag_z = 0, flag_n = 0, flag_c = 0, flag_v = 0;
    logic        res_valid, res_taken, res_unsup;
    logic [31:0] res_next_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural model state and the requirement tag of what produced it.
    bit          m_valid = 0, m_taken = 0, m_unsup = 0;
    logic [31:0] m_pc = '0;
    string       m_tag = "R1";

    always #4 clk = ~clk;

    brr_resolve_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_byte0(req_byte0), .req_byte1(req_byte1), .req_byte2(req_byte2),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
        .res_valid(res_valid), .res_taken(res_taken), .res_unsup(res_unsup),
        .res_next_pc(res_next_pc)
    );

    function automatic void reference(input logic [31:0] pc, input logic [7:0] b0, b1, b2,
                                      input bit z, n, c, v, output bit tk, output bit un,
                                      output logic [31:0] np, output string tag);
        bit known = 1;
        int len = 2;
        int d;
        int op;
        tk = 0;
        if (b0 >= 8'hC0 && b0 <= 8'hCA) begin
            d = int'($signed(b1));
            op = b0 - 8'hC0;
            case (op)
                0: begin tk = (n != v); tag = "R3"; end
                1: begin tk = !(z || (n != v)); tag = "R3"; end
                2: begin tk = (n == v); tag = "R3"; end
                3: begin tk = z || (n != v); tag = "R3"; end
                4: begin tk = c; tag = "R4"; end
                5: begin tk = !(c || z); tag = "R4"; end
                6: begin tk = !c; tag = "R4"; end
                7: begin tk = c || z; tag = "R4"; end
                8: begin tk = z; tag = "R5"; end
                9: begin tk = !z; tag = "R5"; end
                default: begin tk = 1; tag = "R5"; end
            endcase
        end else if (b0 == 8'hF8 && b1 >= 8'hE8 && b1 <= 8'hEB) begin
            d = int'($signed(b2));
            len = 3;
            tag = "R6";
            case (b1)
                8'hE8: tk = !v;
                8'hE9: tk = v;
                8'hEA: tk = !n;
                default: tk = n;
            endcase
        end else begin
            known = 0;
            d = 0;
            tag = (b0 >= 8'hD0 && b0 <= 8'hDB) ? "R9" : "R10";
        end
        un = !known;
        if (!known) np = pc;
        else if (tk) begin np = pc + 32'(d); tag = {tag, "/R7"}; end
        else begin np = pc + 32'(len); tag = {tag, "/R8"}; end
    endfunction

    task automatic compare();
        checks++;
        if (res_valid !== m_valid || res_taken !== m_taken ||
            res_unsup !== m_unsup || res_next_pc !== m_pc) begin
            errors++;
            $display("FAIL %s: got v=%0b t=%0b u=%0b pc=%h expected v=%0b t=%0b u=%0b pc=%h",
                     m_tag, res_valid, res_taken, res_unsup, res_next_pc,
                     m_valid, m_taken, m_unsup, m_pc);
        end
    endtask

    // One clock: check the previous result, drive new inputs, advance the model.
    task automatic tick(input bit rst, input bit v, input logic [31:0] pc,
                        input logic [7:0] b0, b1, b2, input logic [3:0] f);
        bit tk, un;
        logic [31:0] np;
        string tg;
        @(negedge clk);
        compare();
        rst_n = !rst;
        req_valid = v; req_pc = pc;
        req_byte0 = b0; req_byte1 = b1; req_byte2 = b2;
        {flag_z, flag_n, flag_c, flag_v} = f;
        if (rst) begin
            m_valid = 0; m_taken = 0; m_unsup = 0; m_pc = '0; m_tag = "R1";
        end else if (v) begin
            reference(pc, b0, b1, b2, f[3], f[2], f[1], f[0], tk, un, np, tg);
            m_valid = 1; m_taken = tk; m_unsup = un; m_pc = np; m_tag = tg;
        end else begin
            m_valid = 0; m_tag = "R2";
        end
    endtask

    initial begin
        repeat (3) tick(1, 1, 32'h1234, 8'hCA, 8'h10, 0, 4'h0);
        tick(0, 0, 0, 0, 0, 0, 0);
        // Short forms, every flag combination, mixed displacements.
        for (int op = 8'hC0; op <= 8'hCA; op++)
            for (int f = 0; f < 16; f++)
                tick(0, 1, 32'h0000_1000 + 32'(op * 64 + f), 8'(op),
                     8'((f * 37 + op) & 8'hFF), 8'h55, 4'(f));
        // Idle cycles must hold data.
        tick(0, 0, 32'hDEAD_0000, 8'hC8, 8'h01, 0, 4'hF);
        tick(0, 0, 32'hBEEF_0000, 8'hCA, 8'h02, 0, 4'h0);
        // Extended forms.
        for (int s = 8'hE8; s <= 8'hEB; s++)
            for (int f = 0; f < 16; f++) begin
                tick(0, 1, 32'h0002_0000 + 32'(f), 8'hF8, 8'(s), 8'((f * 29) & 8'hFF), 4'(f));
                if (f == 7) tick(0, 0, 0, 0, 0, 0, 0);
            end
        // Wrap-around in both directions.
        tick(0, 1, 32'hFFFF_FFF0, 8'hCA, 8'h7F, 0, 4'h0);
        tick(0, 1, 32'h0000_0004, 8'hCA, 8'h80, 0, 4'h0);
        tick(0, 1, 32'hFFFF_FFFF, 8'hC8, 8'h00, 0, 4'h0);
        tick(0, 1, 32'hFFFF_FFFE, 8'hF8, 8'hE9, 8'h10, 4'h0);
        tick(0, 1, 32'hFFFF_FFF0, 8'hF8, 8'hE8, 8'h7F, 4'h0);
        // Loop-class opcodes.
        for (int op = 8'hD0; op <= 8'hDB; op++)
            tick(0, 1, 32'h0003_0000 + 32'(op), 8'(op), 8'h20, 8'h00, 4'hF);
        // Other unsupported patterns.
        tick(0, 1, 32'h4000_0000, 8'h00, 8'h10, 0, 4'hF);
        tick(0, 1, 32'h4000_0010, 8'hBF, 8'h10, 0, 4'h0);
        tick(0, 1, 32'h4000_0020, 8'hCB, 8'h10, 0, 4'h8);
        tick(0, 1, 32'h4000_0030, 8'hF8, 8'hE7, 8'h10, 4'h1);
        tick(0, 1, 32'h4000_0040, 8'hF8, 8'hEC, 8'h10, 4'h2);
        tick(0, 1, 32'h4000_0050, 8'hFF, 8'hE8, 8'h10, 4'h0);
        tick(0, 1, 32'h4000_0060, 8'hDC, 8'h10, 0, 4'h0);
        tick(0, 0, 0, 0, 0, 0, 0);
        // Reset in mid-run.
        tick(1, 1, 32'h5000_0000, 8'hCA, 8'h10, 0, 4'h0);
        tick(0, 0, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no end, expected finish within 20000 cycles");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule